// File: doc/BRIEF.md
# LPC Memory Target Frame Controller

This block is the bus-facing side of a flash-style memory target on a Low Pin Count bus. It samples the framing strobe and the 4-bit multiplexed address/data lines on every rising bus clock. It decodes memory read and memory write cycles and answers on the shared nibble bus with a ready handshake and, for reads, the data byte. Each accepted write goes out as a single-clock strobe carrying address and byte to the command/status logic. Each read fetches one byte through a synchronous read port with a fixed one-clock latency.

A frame is served only when chip-enable was already low at the clock before the framing strobe first dropped. Other frames are watched until the strobe releases and are then forgotten. If the strobe is held low for four clocks in a row once a cycle is under way, the cycle is dropped. The target then stays silent until the host shows the all-ones abort nibble and keeps it there until the strobe rises. With chip-enable and the strobe both high, no frame open and no write pending inside, the target reports standby.

The write strobe and the read port carry no back-pressure. The consumer of the write strobe must take every pulse in the clock it appears. The read port must return data exactly one clock after the request pulse. These fixed timings are what let the frame run at bus speed with no wait states.

Top module: `lpc_mem_target`

## Requirements
- R1: While `rst_n` is low, `lad_oe`, `wr_valid`, `rd_req` and `standby` are all low.
- R2: A frame opens at a clock where `lframe_n` is low. While it stays low, only the nibble at the last low clock counts, and it must be 4'h0. At the first high clock, the nibble must be 4'b01d0, where d = 1 is a write and d = 0 is a read. Any other start or cycle nibble closes the frame with nothing driven or strobed.
- R3: A frame is served only if `ce_n` was low at the clock before the first low `lframe_n` clock. Otherwise nothing is driven or strobed until `lframe_n` rises.
- R4: A write takes 8 address nibbles, most significant first, and then 2 data nibbles, low nibble first. In the clock after the second data nibble, `wr_valid` is high for exactly one clock, together with `wr_addr` and `wr_data`.
- R5: After the write data, the target leaves the bus undriven for 2 clocks. It drives 4'h0 (ready) for one clock, leaves the bus undriven for 2 more clocks and is then idle.
- R6: A read pulses `rd_req` for one clock, in the clock after the last address nibble, with `rd_addr` valid. `rd_data` is taken one clock after the pulse.
- R7: After the read address, the target leaves the bus undriven for 2 clocks. It drives 4'h0 for one clock, then the byte's low nibble and then its high nibble, and leaves the bus undriven for 2 clocks.
- R8: Inside a cycle, `lframe_n` low for 1 to 3 clocks in a row pauses the cycle. It resumes where it stopped once `lframe_n` is high again.
- R9: Inside a cycle, a fourth consecutive low `lframe_n` clock drops the cycle. No later strobe or drive comes from it, and the target enters the abort wait.
- R10: In the abort wait, the bus is never driven and all frames are ignored. The target returns to idle at a clock with `lframe_n` high only if the nibble at the preceding low clock was 4'hF. That low clock may be the last of a run of 4'hF nibbles.
- R11: `standby` is high in the clock after an edge at which the target was idle, `ce_n` and `lframe_n` were high and `wr_busy` was low. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| lframe_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| wr_busy | input | 1 | An internal write operation is pending |
| wr_valid | output | 1 | One-clock write strobe |
| wr_addr | output | 32 | Write address |
| wr_data | output | 8 | Write byte |
| rd_req | output | 1 | One-clock read request |
| rd_addr | output | 32 | Read address |
| rd_data | input | 8 | Read byte, valid one clock after `rd_req` |
| standby | output | 1 | Target is in standby |

## Verification
The bench opens frames with chip-enable falling in the same clock as the strobe, which exposes a design that qualifies on the current chip-enable instead of the previous one: it would answer a frame it must ignore. It stretches the start phase so that a non-zero nibble is followed by zero, and the reverse, which catches a design that latches the first start nibble rather than the last. It pauses a read for three low clocks and checks that the byte still comes back intact, then holds the strobe low for four clocks mid-write. An off-by-one abort counter either drops paused cycles or lets the aborted write strobe out. In the abort wait it releases the strobe after a non-ones nibble and after a ones nibble, so a design that leaves on any release, or forgets a broken ones run, answers the next frame when it must not, or stays mute when it must not.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SKIP,
    ST_START,
    ST_ADDR,
    ST_WDAT,
    ST_TAR,
    ST_SYNC,
    ST_RDAT,
    ST_TARB,
    ST_ABWAIT
  } tgt_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_ABORT = 4'hF;
  localparam logic [3:0] NIB_READY = 4'h0;

  // memory cycle nibble: 01d0, d = write
  function automatic logic is_mem_cyc(input logic [3:0] n);
    return (n[3:2] == 2'b01) && !n[0];
  endfunction

endpackage

// File: rtl/lpc_tgt_lowrun.sv
// Counts consecutive low frame-strobe clocks while a cycle is open.
module lpc_tgt_lowrun #(
  parameter int LOWS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lframe_n,
  output logic hit
);
  localparam int CW = $clog2(LOWS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOWS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!en || lframe_n) cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign hit = en && !lframe_n && (cnt == LAST);
endmodule

// File: rtl/lpc_tgt_abtcmd.sv
// Watches for the all-ones nibble held until the frame strobe rises.
module lpc_tgt_abtcmd (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       lframe_n,
  input  logic [3:0] lad,
  output logic       done
);
  import lpc_tgt_pkg::*;

  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n)         armed <= 1'b0;
    else if (!en)       armed <= 1'b0;
    else if (!lframe_n) armed <= (lad == NIB_ABORT);
  end

  assign done = en && lframe_n && armed;
endmodule

// File: rtl/lpc_tgt_nibsh.sv
// Nibble shift register, order chosen by parameter.
module lpc_tgt_nibsh #(
  parameter int NIBS      = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        nib,
  output logic [4*NIBS-1:0] q
);
  localparam int W = 4 * NIBS;

  generate
    if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[W-5:0], nib};
      end
    end else begin : g_lsb
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {nib, q[W-1:4]};
      end
    end
  endgenerate
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target #(
  parameter int ADDR_NIBS  = 8,
  parameter int DATA_W     = 8,
  parameter int TAR_CLKS   = 2,
  parameter int ABORT_LOWS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   lframe_n,
  input  logic [3:0]             lad_in,
  output logic [3:0]             lad_out,
  output logic                   lad_oe,
  input  logic                   wr_busy,
  output logic                   wr_valid,
  output logic [4*ADDR_NIBS-1:0] wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   rd_req,
  output logic [4*ADDR_NIBS-1:0] rd_addr,
  input  logic [DATA_W-1:0]      rd_data,
  output logic                   standby
);
  import lpc_tgt_pkg::*;

  localparam int ADDR_W    = 4 * ADDR_NIBS;
  localparam int DATA_NIBS = DATA_W / 4;
  localparam int IDX_MAX   = (ADDR_NIBS > TAR_CLKS) ? ADDR_NIBS : TAR_CLKS;
  localparam int IW        = $clog2(IDX_MAX + 1);
  localparam int DB        = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1;

  tgt_state_e          st;
  logic [IW-1:0]       idx;
  logic                ce_q, is_wr, start_ok, rd_pend;
  logic [DATA_W-1:0]   dbuf;
  logic [ADDR_W-1:0]   addr_q;
  logic                mid, abort_hit, abort_done, in_skip;
  logic [3:0]          dnib [DATA_NIBS];

  assign mid = (st == ST_ADDR) || (st == ST_WDAT) || (st == ST_TAR) ||
               (st == ST_SYNC) || (st == ST_RDAT) || (st == ST_TARB);
  assign in_skip = (st == ST_SKIP);

  lpc_tgt_lowrun #(.LOWS(ABORT_LOWS)) u_lowrun (
    .clk(clk), .rst_n(rst_n), .en(mid), .lframe_n(lframe_n), .hit(abort_hit)
  );

  lpc_tgt_abtcmd u_abtcmd (
    .clk(clk), .rst_n(rst_n), .en(st == ST_ABWAIT), .lframe_n(lframe_n),
    .lad(lad_in), .done(abort_done)
  );

  lpc_tgt_nibsh #(.NIBS(ADDR_NIBS), .MSB_FIRST(1'b1)) u_addr_sh (
    .clk(clk), .rst_n(rst_n), .en((st == ST_ADDR) && lframe_n),
    .nib(lad_in), .q(addr_q)
  );

  lpc_tgt_nibsh #(.NIBS(DATA_NIBS), .MSB_FIRST(1'b0)) u_data_sh (
    .clk(clk), .rst_n(rst_n), .en((st == ST_WDAT) && lframe_n),
    .nib(lad_in), .q(wr_data)
  );

  assign wr_addr = addr_q;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      ce_q     <= 1'b0;
      is_wr    <= 1'b0;
      start_ok <= 1'b0;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      rd_pend  <= 1'b0;
      dbuf     <= '0;
      standby  <= 1'b0;
    end else begin
      ce_q     <= !ce_n;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      rd_pend  <= rd_req;
      if (rd_pend) dbuf <= rd_data;
      standby  <= (st == ST_IDLE) && ce_n && lframe_n && !wr_busy;

      if (abort_hit) begin
        st  <= ST_ABWAIT;
        idx <= '0;
      end else begin
        case (st)
          ST_IDLE: if (!lframe_n) begin
            st       <= ce_q ? ST_START : ST_SKIP;
            start_ok <= (lad_in == NIB_START);
          end
          ST_SKIP: if (lframe_n) st <= ST_IDLE;
          ST_START: begin
            if (!lframe_n) start_ok <= (lad_in == NIB_START);
            else if (start_ok && is_mem_cyc(lad_in)) begin
              st    <= ST_ADDR;
              is_wr <= lad_in[1];
              idx   <= '0;
            end else st <= ST_IDLE;
          end
          ST_ABWAIT: if (abort_done) st <= ST_IDLE;
          default: if (lframe_n) begin
            case (st)
              ST_ADDR: if (idx == IW'(ADDR_NIBS - 1)) begin
                idx <= '0;
                if (is_wr) st <= ST_WDAT;
                else begin
                  st     <= ST_TAR;
                  rd_req <= 1'b1;
                end
              end else idx <= idx + 1'b1;
              ST_WDAT: if (idx == IW'(DATA_NIBS - 1)) begin
                idx      <= '0;
                st       <= ST_TAR;
                wr_valid <= 1'b1;
              end else idx <= idx + 1'b1;
              ST_TAR: if (idx == IW'(TAR_CLKS - 1)) begin
                idx <= '0;
                st  <= ST_SYNC;
              end else idx <= idx + 1'b1;
              ST_SYNC: st <= is_wr ? ST_TARB : ST_RDAT;
              ST_RDAT: if (idx == IW'(DATA_NIBS - 1)) begin
                idx <= '0;
                st  <= ST_TARB;
              end else idx <= idx + 1'b1;
              ST_TARB: if (idx == IW'(TAR_CLKS - 1)) begin
                idx <= '0;
                st  <= ST_IDLE;
              end else idx <= idx + 1'b1;
              default: st <= ST_IDLE;
            endcase
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_dnib
    assign dnib[g] = dbuf[4*g +: 4];
  end

  assign lad_oe = (st == ST_SYNC) || (st == ST_RDAT);

  always_comb begin
    if (st == ST_RDAT) lad_out = dnib[idx[DB-1:0]];
    else               lad_out = NIB_READY;
  end
endmodule

// File: rtl/lpc_mem_target_chk.sv
module lpc_mem_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       lframe_n,
  input logic       wr_busy,
  input logic       lad_oe,
  input logic [3:0] lad_out,
  input logic       wr_valid,
  input logic       rd_req,
  input logic       standby,
  input logic       abort_hit,
  input logic       in_skip
);
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !lad_oe);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_ready_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (lad_out == 4'h0));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!lad_oe && !wr_valid && !rd_req));

  assert_standby_cond_R11: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> ($past(ce_n) && $past(lframe_n) && !$past(wr_busy)));
endmodule

bind lpc_mem_target lpc_mem_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lframe_n(lframe_n),
  .wr_busy(wr_busy), .lad_oe(lad_oe), .lad_out(lad_out),
  .wr_valid(wr_valid), .rd_req(rd_req), .standby(standby),
  .abort_hit(abort_hit), .in_skip(in_skip)
);

// File: tb/lpc_mem_target_bench.sv
module lpc_mem_target_bench;
  logic        clk = 1'b0;
  logic        rst_n, ce_n, lframe_n, wr_busy;
  logic [3:0]  lad_in, lad_out;
  logic        lad_oe, wr_valid, rd_req, standby;
  logic [31:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data = 8'h00;

  always #5 clk = ~clk;

  lpc_mem_target u_lpc_mem_target (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lframe_n(lframe_n),
    .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .wr_busy(wr_busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .standby(standby)
  );

  function automatic logic [7:0] mem_f(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);

  int errs = 0, checks = 0, wr_cnt = 0;
  logic [7:0] last_wd;
  logic [3:0] drv_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: modes 0 idle, 1 ignored frame, 2 start, 3 cycle body, 4 abort wait
  int m_mode = 0, m_pos = 0, m_low = 0;
  bit m_cep = 0, m_sok = 0, m_wr = 0, m_arm = 0;
  logic [31:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  bit e_wrv = 0, e_rdq = 0, e_sb = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cep = 0; e_wrv = 0; e_rdq = 0; e_sb = 0;
    end else begin
      e_sb  = (m_mode == 0) && ce_n && lframe_n && !wr_busy;
      e_wrv = 0;
      e_rdq = 0;
      case (m_mode)
        0: if (!lframe_n) begin
          m_mode = m_cep ? 2 : 1;
          m_sok  = (lad_in == 4'h0);
        end
        1: if (lframe_n) m_mode = 0;
        2: if (!lframe_n) m_sok = (lad_in == 4'h0);
           else if (m_sok && lad_in[3:2] == 2'b01 && !lad_in[0]) begin
             m_mode = 3; m_wr = lad_in[1]; m_pos = 0; m_low = 0;
           end else m_mode = 0;
        3: if (!lframe_n) begin
          m_low++;
          if (m_low == 4) begin m_mode = 4; m_arm = 0; end
        end else begin
          m_low = 0;
          m_pos++;
          if (m_pos <= 8) m_addr = {m_addr[27:0], lad_in};
          if (m_wr && m_pos == 9) m_wd[3:0] = lad_in;
          if (m_wr && m_pos == 10) begin m_wd[7:4] = lad_in; e_wrv = 1; end
          if (!m_wr && m_pos == 8) e_rdq = 1;
          if (m_pos == 15) m_mode = 0;
        end
        default: if (!lframe_n) m_arm = (lad_in == 4'hF);
                 else if (m_arm) m_mode = 0;
      endcase
      m_cep = !ce_n;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_oe;
      logic [3:0] e_nib;
      logic [7:0] b;
      string t;
      b = mem_f(m_addr);
      e_oe = (m_mode == 3) && (m_wr ? (m_pos == 12) : (m_pos >= 10 && m_pos <= 12));
      e_nib = (m_wr || m_pos == 10) ? 4'h0 : (m_pos == 11 ? b[3:0] : b[7:4]);
      t = (m_mode == 4) ? "R10" : (m_mode == 1) ? "R3" :
          (m_mode == 3) ? (m_wr ? "R5" : "R7") : "R2";
      chk({t, " drive"}, lad_oe, e_oe);
      if (e_oe) chk({t, " nibble"}, lad_out, e_nib);
      chk("R4 strobe", wr_valid, e_wrv);
      if (e_wrv) begin
        chk("R4 addr", wr_addr, m_addr);
        chk("R4 data", wr_data, m_wd);
      end
      chk("R6 request", rd_req, e_rdq);
      if (e_rdq) chk("R6 addr", rd_addr, m_addr);
      chk("R11 standby", standby, e_sb);
      if (lad_oe) drv_q.push_back(lad_out);
      if (wr_valid) begin wr_cnt++; last_wd = wr_data; end
    end
  end

  task automatic drive(input logic lf, input logic [3:0] n);
    @(negedge clk);
    lframe_n = lf;
    lad_in   = n;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 4'hF);
  endtask

  task automatic body(input logic [3:0] cyc, input logic [31:0] a, input logic [7:0] d);
    drive(1'b1, cyc);
    for (int i = 7; i >= 0; i--) drive(1'b1, a[4*i +: 4]);
    if (cyc[1]) begin
      drive(1'b1, d[3:0]);
      drive(1'b1, d[7:4]);
    end
    idle(9);
  endtask

  task automatic expect_drv(input string tag, input int n, input logic [3:0] n0,
                            input logic [3:0] n1, input logic [3:0] n2);
    logic [3:0] ex[3];
    ex[0] = n0; ex[1] = n1; ex[2] = n2;
    chk({tag, " driven count"}, drv_q.size(), n);
    for (int i = 0; i < n && i < drv_q.size(); i++) chk({tag, " driven nibble"}, drv_q[i], ex[i]);
    drv_q.delete();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int w0;
    rst_n = 0; ce_n = 1; lframe_n = 1; lad_in = 4'hF; wr_busy = 0;
    repeat (3) @(negedge clk);
    chk("R1 oe", lad_oe, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 standby", standby, 0);
    rst_n = 1;
    idle(4);
    chk("R11 standby idle", standby, 1);
    wr_busy = 1;
    idle(2);
    chk("R11 standby busy", standby, 0);
    wr_busy = 0;
    ce_n = 0;
    idle(2);
    chk("R11 standby ce", standby, 0);

    // plain write
    drive(1'b0, 4'h0);
    body(4'b0110, 32'h1234_56A5, 8'h3C);
    expect_drv("R5", 1, 4'h0, 4'h0, 4'h0);
    chk("R4 count", wr_cnt, 1);
    chk("R4 byte", last_wd, 8'h3C);

    // plain read: 0x77 ^ 0x5A = 0x2D
    drive(1'b0, 4'h0);
    body(4'b0100, 32'h0000_0077, 8'h00);
    expect_drv("R7", 3, 4'h0, 4'hD, 4'h2);

    // stretched start, last nibble zero: 0x10 ^ 0x5A = 0x4A
    drive(1'b0, 4'h5);
    drive(1'b0, 4'h0);
    body(4'b0100, 32'h0000_0010, 8'h00);
    expect_drv("R2 last start", 3, 4'h0, 4'hA, 4'h4);

    // stretched start, last nibble non-zero
    drive(1'b0, 4'h0);
    drive(1'b0, 4'h3);
    body(4'b0100, 32'h0000_0010, 8'h00);
    expect_drv("R2 bad start", 0, 4'h0, 4'h0, 4'h0);

    // unknown cycle type
    w0 = wr_cnt;
    drive(1'b0, 4'h0);
    body(4'b0010, 32'h0000_0055, 8'h11);
    expect_drv("R2 bad type", 0, 4'h0, 4'h0, 4'h0);
    chk("R2 no strobe", wr_cnt, w0);

    // chip enable arriving with the frame strobe
    ce_n = 1;
    idle(2);
    @(negedge clk);
    ce_n = 0; lframe_n = 0; lad_in = 4'h0;
    body(4'b0110, 32'h0000_0099, 8'h77);
    expect_drv("R3 late ce", 0, 4'h0, 4'h0, 4'h0);
    chk("R3 no strobe", wr_cnt, w0);

    // paused read: 0xA1 ^ 0x5A = 0xFB
    drive(1'b0, 4'h0);
    drive(1'b1, 4'b0100);
    for (int i = 7; i >= 5; i--) drive(1'b1, 4'h0);
    for (int i = 0; i < 3; i++) drive(1'b0, 4'h0);
    drive(1'b1, 4'h0);
    drive(1'b1, 4'h0);
    drive(1'b1, 4'h0);
    drive(1'b1, 4'hA);
    drive(1'b1, 4'h1);
    idle(9);
    expect_drv("R8 paused", 3, 4'h0, 4'hB, 4'hF);

    // abort mid-write
    w0 = wr_cnt;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'b0110);
    for (int i = 0; i < 4; i++) drive(1'b1, 4'h1);
    for (int i = 0; i < 4; i++) drive(1'b0, 4'h0);
    idle(12);
    chk("R9 dropped", wr_cnt, w0);
    expect_drv("R9", 0, 4'h0, 4'h0, 4'h0);

    // frames ignored during abort wait
    drive(1'b0, 4'h0);
    body(4'b0100, 32'h0000_0022, 8'h00);
    expect_drv("R10 ignored", 0, 4'h0, 4'h0, 4'h0);

    // broken abort nibble run
    drive(1'b0, 4'hF);
    drive(1'b0, 4'h3);
    idle(2);
    drive(1'b0, 4'h0);
    body(4'b0100, 32'h0000_0022, 8'h00);
    expect_drv("R10 broken", 0, 4'h0, 4'h0, 4'h0);

    // proper abort, then service resumes: 0x33 ^ 0x5A = 0x69
    drive(1'b0, 4'hF);
    drive(1'b0, 4'hF);
    idle(2);
    chk("R11 after abort", standby, 0);
    drive(1'b0, 4'h0);
    body(4'b0100, 32'h0000_0033, 8'h00);
    expect_drv("R10 ready", 3, 4'h0, 4'h9, 4'h6);

    idle(3);
    finish_run();
  end
endmodule